// File: doc/BRIEF.md
# USB Controller Interrupt Aggregator

This block collects the interrupt events of a USB dual-role controller (transmit-endpoint, receive-endpoint and core events) into one 32-bit pending word. Software reads the pending word and never writes it directly. It sets bits through a write-one-to-set alias and clears them through a write-one-to-clear alias. An enable mask is changed the same way, through its own set and clear aliases. A read-only view returns the pending bits that are enabled.

A single level interrupt line drives the CPU. Once it rises, it stays high until software writes the end-of-interrupt register. That write lowers the line and re-arms it. If enabled bits are still pending, the line rises again on the following cycle. A handler therefore works in a fixed order: read the masked view, clear what it serviced, then write end-of-interrupt.

Top module: `usb_irq_agg`

## Requirements
- R1: Reset clears the pending word and the mask, holds the interrupt line low, and leaves the line armed.
- R2: Transmit event `tx_evt[i]` sets pending bit i (bits 0..4). Receive event `rx_evt[j]` sets bit 9+j (bits 9..12). Core event `core_evt[k]` sets bit 16+k (bits 16..24, with bit 24 being the VBUS-drive change event). Every other bit, bit 8 included, always reads 0 and cannot be set.
- R3: Byte addresses: 0x20 pending (read-only), 0x24 pending-set, 0x28 pending-clear, 0x2C mask (read-only), 0x30 mask-set, 0x34 mask-clear, 0x38 masked pending (read-only), 0x3C end-of-interrupt. Writes to read-only addresses change nothing. Reads of any other address return 0.
- R4: A write to a set or clear alias changes only the bits written as 1. All other bits keep their value.
- R5: When a hardware event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R6: The masked view at 0x38 reads as the bitwise AND of the pending word and the mask.
- R7: While armed, the line rises one clock after the masked pending value becomes non-zero. It then stays high until an end-of-interrupt write, even if the pending bits are cleared.
- R8: An end-of-interrupt write, with any data value, lowers the line at the clock edge where it is taken and re-arms it. The line rises again one clock later if masked bits are still pending.
- R9: An event present at a clock edge, or a register write taken at that edge, shows up in a read of the affected register straight after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write enable, write taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| tx_evt | input | 5 | Transmit-endpoint event pulses (endpoint 0 plus four) |
| rx_evt | input | 4 | Receive-endpoint event pulses |
| core_evt | input | 9 | Core event pulses, top bit is the VBUS-drive change |
| irq_o | output | 1 | Level interrupt to the CPU |

## Verification
Register contents change at the edge where a write or event is taken, and the combinational read path shows the new value straight after that edge. The interrupt line depends on registered pending and mask state, so it follows one edge later than the register contents. The bench applies each table step for exactly one edge. It then parks the bus on the step's read address and compares the read data with the line level one time unit after that edge. Expected line levels in the table are worked out from the pending and mask state held before each edge, and the end-of-interrupt rearm is counted as its own edge.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;

    localparam int DW       = 32;
    localparam int AW       = 8;
    localparam int N_TX     = 5;
    localparam int N_RX     = 4;
    localparam int N_CORE   = 9;
    localparam int TX_LSB   = 0;
    localparam int RX_LSB   = 9;
    localparam int CORE_LSB = 16;

    localparam logic [AW-1:0] A_PEND  = 8'h20;
    localparam logic [AW-1:0] A_PSET  = 8'h24;
    localparam logic [AW-1:0] A_PCLR  = 8'h28;
    localparam logic [AW-1:0] A_ENB   = 8'h2C;
    localparam logic [AW-1:0] A_ESET  = 8'h30;
    localparam logic [AW-1:0] A_ECLR  = 8'h34;
    localparam logic [AW-1:0] A_ACTV  = 8'h38;
    localparam logic [AW-1:0] A_EOI   = 8'h3C;

    typedef struct packed {
        logic [DW-1:0] bits;
    } word_st_t;

    typedef struct packed {
        logic armed;
        logic line;
    } line_st_t;

endpackage

// File: rtl/usbirq_evt_map.sv
module usbirq_evt_map #(
    parameter int DW       = usbirq_pkg::DW,
    parameter int N_TX     = usbirq_pkg::N_TX,
    parameter int N_RX     = usbirq_pkg::N_RX,
    parameter int N_CORE   = usbirq_pkg::N_CORE,
    parameter int TX_LSB   = usbirq_pkg::TX_LSB,
    parameter int RX_LSB   = usbirq_pkg::RX_LSB,
    parameter int CORE_LSB = usbirq_pkg::CORE_LSB
) (
    input  logic [N_TX-1:0]   tx_i,
    input  logic [N_RX-1:0]   rx_i,
    input  logic [N_CORE-1:0] core_i,
    output logic [DW-1:0]     evt_o,
    output logic [DW-1:0]     keep_o
);
    // Place each event group at its field; all other bits are zero.
    for (genvar b = 0; b < DW; b++) begin : g_bit
        if (b >= TX_LSB && b < TX_LSB + N_TX) begin : g_tx
            assign evt_o[b]  = tx_i[b - TX_LSB];
            assign keep_o[b] = 1'b1;
        end else if (b >= RX_LSB && b < RX_LSB + N_RX) begin : g_rx
            assign evt_o[b]  = rx_i[b - RX_LSB];
            assign keep_o[b] = 1'b1;
        end else if (b >= CORE_LSB && b < CORE_LSB + N_CORE) begin : g_core
            assign evt_o[b]  = core_i[b - CORE_LSB];
            assign keep_o[b] = 1'b1;
        end else begin : g_none
            assign evt_o[b]  = 1'b0;
            assign keep_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/usbirq_w1_reg.sv
module usbirq_w1_reg #(
    parameter int DW = usbirq_pkg::DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] set_i,
    input  logic [DW-1:0] clr_i,
    input  logic [DW-1:0] hw_i,
    input  logic [DW-1:0] keep_i,
    output logic [DW-1:0] q_o
);
    import usbirq_pkg::*;

    typedef struct packed {
        logic [DW-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    // Software clear beats software set; a hardware event beats both.
    always_comb begin
        st_d      = st_q;
        st_d.bits = (((st_q.bits | set_i) & ~clr_i) | hw_i) & keep_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.bits;

    // R5
    evt_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_i & keep_i) != '0) |=> ((q_o & $past(hw_i & keep_i)) == $past(hw_i & keep_i)));

    // R4
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~hw_i) != '0) |=> ((q_o & $past(clr_i & ~hw_i)) == '0));

    // R4
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i | clr_i | hw_i) == '0) |=> $stable(q_o));
endmodule

// File: rtl/usbirq_line.sv
module usbirq_line (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic eoi_i,
    output logic irq_o
);
    import usbirq_pkg::*;

    line_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (eoi_i) begin
            st_d.armed = 1'b1;
            st_d.line  = 1'b0;
        end else if (st_q.armed && pend_i) begin
            st_d.armed = 1'b0;
            st_d.line  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{armed: 1'b1, line: 1'b0};
        else        st_q <= st_d;
    end

    assign irq_o = st_q.line;

    // R7
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !eoi_i) |=> irq_o);

    // R7
    line_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && pend_i && !eoi_i) |=> irq_o);

    // R8
    eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_i |=> !irq_o);

    // R7
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !pend_i) |=> !irq_o);
endmodule

// File: rtl/usb_irq_agg.sv
module usb_irq_agg #(
    parameter int DW       = usbirq_pkg::DW,
    parameter int AW       = usbirq_pkg::AW,
    parameter int N_TX     = usbirq_pkg::N_TX,
    parameter int N_RX     = usbirq_pkg::N_RX,
    parameter int N_CORE   = usbirq_pkg::N_CORE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [N_TX-1:0]   tx_evt,
    input  logic [N_RX-1:0]   rx_evt,
    input  logic [N_CORE-1:0] core_evt,
    output logic              irq_o
);
    import usbirq_pkg::*;

    logic [DW-1:0] evt_w, keep_w;
    logic [DW-1:0] pend_q, enb_q, actv_w;
    logic [DW-1:0] pset_w, pclr_w, eset_w, eclr_w;
    logic          eoi_w;

    usbirq_evt_map #(
        .DW(DW), .N_TX(N_TX), .N_RX(N_RX), .N_CORE(N_CORE),
        .TX_LSB(TX_LSB), .RX_LSB(RX_LSB), .CORE_LSB(CORE_LSB)
    ) u_map (
        .tx_i(tx_evt), .rx_i(rx_evt), .core_i(core_evt),
        .evt_o(evt_w), .keep_o(keep_w)
    );

    // Write decode: each alias produces a one-cycle bit vector.
    always_comb begin
        pset_w = '0;
        pclr_w = '0;
        eset_w = '0;
        eclr_w = '0;
        eoi_w  = 1'b0;
        if (bus_we) begin
            unique case (bus_addr)
                A_PSET:  pset_w = bus_wdata;
                A_PCLR:  pclr_w = bus_wdata;
                A_ESET:  eset_w = bus_wdata;
                A_ECLR:  eclr_w = bus_wdata;
                A_EOI:   eoi_w  = 1'b1;
                default: ;
            endcase
        end
    end

    usbirq_w1_reg #(.DW(DW)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .set_i(pset_w), .clr_i(pclr_w), .hw_i(evt_w), .keep_i(keep_w),
        .q_o(pend_q)
    );

    usbirq_w1_reg #(.DW(DW)) u_enb (
        .clk(clk), .rst_n(rst_n),
        .set_i(eset_w), .clr_i(eclr_w), .hw_i('0), .keep_i(keep_w),
        .q_o(enb_q)
    );

    assign actv_w = pend_q & enb_q;

    usbirq_line u_line (
        .clk(clk), .rst_n(rst_n),
        .pend_i(|actv_w), .eoi_i(eoi_w),
        .irq_o(irq_o)
    );

    always_comb begin
        unique case (bus_addr)
            A_PEND:  bus_rdata = pend_q;
            A_ENB:   bus_rdata = enb_q;
            A_ACTV:  bus_rdata = actv_w;
            default: bus_rdata = '0;
        endcase
    end

    // R3
    ro_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_PEND && evt_w == '0) |=> $stable(pend_q));

    // R3
    ro_enb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_ENB) |=> $stable(enb_q));
endmodule

// File: tb/usb_irq_agg_tb.sv
`timescale 1ns/1ps
module usb_irq_agg_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  tx_evt = '0;
    logic [3:0]  rx_evt = '0;
    logic [8:0]  core_evt = '0;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    usb_irq_agg u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt),
        .rx_evt(rx_evt), .core_evt(core_evt), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic        we;
        logic [31:0] wd;
        logic [4:0]  tx;
        logic [3:0]  rx;
        logic [8:0]  core;
        logic [7:0]  ra;
        logic [31:0] exp;
        logic        eirq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{8'h30,1'b1,32'h0000001F,5'h00,4'h0,9'h000,8'h2C,32'h0000001F,1'b0,4'd4}, // R4
        '{8'h00,1'b0,32'h0,       5'h04,4'h0,9'h000,8'h20,32'h00000004,1'b0,4'd9}, // R9 R2
        '{8'h00,1'b0,32'h0,       5'h00,4'h0,9'h000,8'h38,32'h00000004,1'b1,4'd7}, // R7
        '{8'h28,1'b1,32'h00000004,5'h00,4'h0,9'h000,8'h20,32'h00000000,1'b1,4'd7}, // R7 hold
        '{8'h3C,1'b1,32'h0,       5'h00,4'h0,9'h000,8'h20,32'h00000000,1'b0,4'd8}, // R8
        '{8'h00,1'b0,32'h0,       5'h00,4'h0,9'h000,8'h20,32'h00000000,1'b0,4'd8}, // R8
        '{8'h00,1'b0,32'h0,       5'h00,4'h1,9'h000,8'h20,32'h00000200,1'b0,4'd2}, // R2
        '{8'h00,1'b0,32'h0,       5'h00,4'h0,9'h000,8'h38,32'h00000000,1'b0,4'd6}, // R6
        '{8'h30,1'b1,32'h01FF0000,5'h00,4'h0,9'h000,8'h2C,32'h01FF001F,1'b0,4'd4}, // R4
        '{8'h24,1'b1,32'h01000000,5'h00,4'h0,9'h000,8'h20,32'h01000200,1'b0,4'd4}, // R4
        '{8'h00,1'b0,32'h0,       5'h00,4'h0,9'h000,8'h38,32'h01000000,1'b1,4'd7}, // R7
        '{8'h34,1'b1,32'h01000000,5'h00,4'h0,9'h000,8'h2C,32'h00FF001F,1'b1,4'd4}, // R4
        '{8'h3C,1'b1,32'hDEADBEEF,5'h00,4'h0,9'h000,8'h38,32'h00000000,1'b0,4'd8}, // R8
        '{8'h00,1'b0,32'h0,       5'h00,4'h0,9'h000,8'h20,32'h01000200,1'b0,4'd8}, // R8
        '{8'h28,1'b1,32'h00010000,5'h00,4'h0,9'h001,8'h20,32'h01010200,1'b0,4'd5}, // R5
        '{8'h00,1'b0,32'h0,       5'h00,4'h0,9'h000,8'h38,32'h00010000,1'b1,4'd6}, // R6
        '{8'h20,1'b1,32'hFFFFFFFF,5'h00,4'h0,9'h000,8'h20,32'h01010200,1'b1,4'd3}, // R3
        '{8'h3C,1'b1,32'h0,       5'h00,4'h0,9'h000,8'h38,32'h00010000,1'b0,4'd8}, // R8
        '{8'h00,1'b0,32'h0,       5'h00,4'h0,9'h000,8'h38,32'h00010000,1'b1,4'd8}, // R8
        '{8'h24,1'b1,32'hFFFFFFFF,5'h00,4'h0,9'h000,8'h20,32'h01FF1E1F,1'b1,4'd2}, // R2
        '{8'h28,1'b1,32'hFFFFFFFF,5'h00,4'h0,9'h000,8'h20,32'h00000000,1'b1,4'd4}, // R4
        '{8'h34,1'b1,32'hFFFFFFFF,5'h00,4'h0,9'h000,8'h2C,32'h00000000,1'b1,4'd4}, // R4
        '{8'h3C,1'b1,32'h0,       5'h00,4'h0,9'h000,8'h40,32'h00000000,1'b0,4'd3}, // R3
        '{8'h2C,1'b1,32'hFFFFFFFF,5'h00,4'h0,9'h000,8'h2C,32'h00000000,1'b0,4'd3}  // R3
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [7:0] a, input string tag, input logic [31:0] exp);
        bus_addr = a;
        bus_we   = 1'b0;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state held in reset
        peek(8'h20, "R1 pend in reset", 32'h0);
        peek(8'h2C, "R1 mask in reset", 32'h0);
        check("R1 irq in reset", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_addr  = VECS[i].addr;
            bus_we    = VECS[i].we;
            bus_wdata = VECS[i].wd;
            tx_evt    = VECS[i].tx;
            rx_evt    = VECS[i].rx;
            core_evt  = VECS[i].core;
            @(posedge clk);
            #0.5;
            tx_evt   = '0;
            rx_evt   = '0;
            core_evt = '0;
            peek(VECS[i].ra, $sformatf("R%0d step %0d data", VECS[i].req, i), VECS[i].exp);
            check($sformatf("R%0d step %0d irq", VECS[i].req, i), {31'b0, irq_o},
                  {31'b0, VECS[i].eirq});
        end

        // R1: reset after activity, line armed afterwards
        @(negedge clk);
        bus_addr = 8'h30; bus_we = 1'b1; bus_wdata = 32'h1;
        @(negedge clk);
        bus_addr = 8'h24; bus_we = 1'b1; bus_wdata = 32'h1;
        @(negedge clk);
        bus_we = 1'b0;
        @(negedge clk);
        check("R7 line before reset", {31'b0, irq_o}, 32'h1);
        rst_n = 1'b0;
        #1;
        peek(8'h20, "R1 pend after reset", 32'h0);
        peek(8'h2C, "R1 mask after reset", 32'h0);
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 armed: a fresh event plus mask raises the line without any EOI
        bus_addr = 8'h30; bus_we = 1'b1; bus_wdata = 32'h00000002;
        @(negedge clk);
        bus_we = 1'b0;
        tx_evt = 5'h02;
        @(negedge clk);
        tx_evt = '0;
        peek(8'h20, "R9 event visible", 32'h2);
        @(negedge clk);
        check("R1 armed after reset", {31'b0, irq_o}, 32'h1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule